// File: doc/BRIEF.md
# Refresh Phase Sequencer

This block drives a dynamic memory array from one external cycle clock. It samples that cycle clock on a fast clock and counts the fast-clock edges that follow each accepted rising edge of the cycle clock. From that count it decodes four strobes in a fixed order:

- a row-select strobe and an address-enable strobe for the read or write access;
- a whole-array refresh strobe;
- a restore strobe for recharging.

It also raises a one-cycle pulse at the end of the access window. The same counter polices the cycle clock. A rising edge that comes too soon after the last accepted one is ignored and flagged. A gap long enough to put stored data at risk is flagged too. Both flags stay set until reset.

The tick counter replaces a tapped delay line. Tick 0 is the fast-clock cycle that starts at the sampling edge where the cycle clock is first seen high after being low. The spacing between two rising edges is the number of fast-clock sampling edges from one detection to the next. The default tick positions assume a 10 ns sample clock: a 400 ns minimum cycle and a 1.2 us maximum refresh interval.

Top module: `refresh_phase_sequencer`

## Requirements
- R1: While reset is asserted and directly after it, all seven outputs are 0.
- R2: After an accepted rising edge, row_sel is 1 for ticks 0 to 19 and 0 otherwise.
- R3: addr_en is 1 for ticks 0 to 19, and refresh is 1 for ticks 22 to 35. addr_en is never 1 while refresh is 1.
- R4: restore is 1 for ticks 24 to 35, and only while refresh is 1.
- R5: data_valid is a single-cycle pulse at tick 25 of each accepted cycle.
- R6: From tick 36 until the next accepted rising edge, all four strobes are 0.
- R7: A rising edge whose spacing from the last accepted edge is below 40 is ignored, so the running sequence continues unchanged. It sets cycle_violation.
- R8: A rising edge at a spacing of exactly 40 is accepted and sets no flag.
- R9: refresh_violation is set once 120 sampling edges pass with no accepted edge, counted from the last accepted edge or from reset. An edge at a spacing of exactly 120 is accepted without setting the flag.
- R10: cycle_violation and refresh_violation stay at 1 until reset.
- R11: The first rising edge after reset is accepted whatever its spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_clk | input | 1 | External memory cycle clock, sampled on clk |
| row_sel | output | 1 | Word/bit selection strobe for the access |
| addr_en | output | 1 | Address inverter enable, access phase only |
| refresh | output | 1 | All-word-line refresh strobe |
| restore | output | 1 | Recharge strobe inside the refresh phase |
| data_valid | output | 1 | End-of-access-window pulse |
| cycle_violation | output | 1 | Sticky: a cycle clock edge came too early |
| refresh_violation | output | 1 | Sticky: the refresh interval was exceeded |

## Verification
Two events can fall on the same sampling edge: the starvation threshold and a rising edge that arrives exactly as the 120th tick completes. In that case the edge must win, so the sequence restarts and no flag is set. The bench provokes this with one gap of exactly 120 and a second gap of exactly 121, and judges it by refresh_violation. It also places an early edge inside the refresh phase, where the ignored edge lands in the same cycle as live strobes. A cycle-accurate model in the bench then checks every output on every cycle.

// File: rtl/rps_pkg.sv
package rps_pkg;

  // True when tick t lies in the half-open window [lo, hi).
  function automatic logic in_span(input int unsigned t, input int unsigned lo,
                                   input int unsigned hi);
    return (t >= lo) && (t < hi);
  endfunction

  // Spacing of an edge seen while the counter shows tick t.
  function automatic int unsigned gap_of(input int unsigned t);
    return t + 1;
  endfunction

endpackage

// File: rtl/rps_edge_detect.sv
module rps_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_in,
  output logic rise_o
);
  logic cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_q <= 1'b0;
    else        cyc_q <= cyc_in;
  end

  assign rise_o = cyc_in & ~cyc_q;
endmodule

// File: rtl/rps_tick_counter.sv
module rps_tick_counter #(
  parameter int MIN_GAP = 40,
  parameter int MAX_GAP = 120,
  parameter int TW      = $clog2(MAX_GAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  output logic [TW-1:0] tick_o,
  output logic          active_o,
  output logic          accept_o,
  output logic          early_o,
  output logic          starve_o
);
  import rps_pkg::*;

  localparam logic [TW-1:0] TICK_SAT  = TW'(MAX_GAP);
  localparam logic [TW-1:0] TICK_LAST = TW'(MAX_GAP - 1);

  logic          spaced_ok;
  logic [TW-1:0] tick_q;
  logic          active_q;

  assign spaced_ok = gap_of(32'(tick_q)) >= MIN_GAP;
  assign accept_o  = rise_i && (!active_q || spaced_ok);
  assign early_o   = rise_i && active_q && !spaced_ok;
  assign starve_o  = !accept_o && (tick_q == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q   <= '0;
      active_q <= 1'b0;
    end else if (accept_o) begin
      tick_q   <= '0;
      active_q <= 1'b1;
    end else if (tick_q != TICK_SAT) begin
      tick_q   <= tick_q + 1'b1;
    end
  end

  assign tick_o   = tick_q;
  assign active_o = active_q;
endmodule

// File: rtl/rps_phase_decode.sv
module rps_phase_decode #(
  parameter int ROW_END    = 20,
  parameter int REF_BEGIN  = 22,
  parameter int RST_BEGIN  = 24,
  parameter int PHASE_END  = 36,
  parameter int VALID_TICK = 25,
  parameter int TW         = 7
) (
  input  logic [TW-1:0] tick_i,
  input  logic          active_i,
  output logic          row_sel_o,
  output logic          addr_en_o,
  output logic          refresh_o,
  output logic          restore_o,
  output logic          data_valid_o
);
  import rps_pkg::*;

  logic [31:0] t;
  logic        access_win;

  assign t          = 32'(tick_i);
  assign access_win = active_i && in_span(t, 0, ROW_END);

  always_comb begin
    row_sel_o    = access_win;
    addr_en_o    = access_win;
    refresh_o    = active_i && in_span(t, REF_BEGIN, PHASE_END);
    restore_o    = active_i && in_span(t, RST_BEGIN, PHASE_END);
    data_valid_o = active_i && in_span(t, VALID_TICK, VALID_TICK + 1);
  end
endmodule

// File: rtl/rps_rule_monitor.sv
module rps_rule_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic early_i,
  input  logic starve_i,
  output logic cycle_flag_o,
  output logic refresh_flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle_flag_o   <= 1'b0;
      refresh_flag_o <= 1'b0;
    end else begin
      if (early_i)  cycle_flag_o   <= 1'b1;
      if (starve_i) refresh_flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/refresh_phase_sequencer.sv
module refresh_phase_sequencer #(
  parameter int ROW_END    = 20,
  parameter int REF_BEGIN  = 22,
  parameter int RST_BEGIN  = 24,
  parameter int PHASE_END  = 36,
  parameter int VALID_TICK = 25,
  parameter int MIN_GAP    = 40,
  parameter int MAX_GAP    = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_clk,
  output logic row_sel,
  output logic addr_en,
  output logic refresh,
  output logic restore,
  output logic data_valid,
  output logic cycle_violation,
  output logic refresh_violation
);
  localparam int TW = $clog2(MAX_GAP + 1);

  // Named internal events, also observed by the bound checker.
  logic          cyc_rise;
  logic [TW-1:0] tick;
  logic          seq_active;
  logic          edge_accept;
  logic          edge_early;
  logic          gap_starve;

  rps_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyc_in (cyc_clk),
    .rise_o (cyc_rise)
  );

  rps_tick_counter #(
    .MIN_GAP (MIN_GAP),
    .MAX_GAP (MAX_GAP),
    .TW      (TW)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (cyc_rise),
    .tick_o   (tick),
    .active_o (seq_active),
    .accept_o (edge_accept),
    .early_o  (edge_early),
    .starve_o (gap_starve)
  );

  rps_phase_decode #(
    .ROW_END    (ROW_END),
    .REF_BEGIN  (REF_BEGIN),
    .RST_BEGIN  (RST_BEGIN),
    .PHASE_END  (PHASE_END),
    .VALID_TICK (VALID_TICK),
    .TW         (TW)
  ) u_decode (
    .tick_i       (tick),
    .active_i     (seq_active),
    .row_sel_o    (row_sel),
    .addr_en_o    (addr_en),
    .refresh_o    (refresh),
    .restore_o    (restore),
    .data_valid_o (data_valid)
  );

  rps_rule_monitor u_rules (
    .clk            (clk),
    .rst_n          (rst_n),
    .early_i        (edge_early),
    .starve_i       (gap_starve),
    .cycle_flag_o   (cycle_violation),
    .refresh_flag_o (refresh_violation)
  );
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int TW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          row_sel,
  input logic          addr_en,
  input logic          refresh,
  input logic          restore,
  input logic          data_valid,
  input logic          cycle_violation,
  input logic          refresh_violation,
  input logic [TW-1:0] tick,
  input logic          edge_early,
  input logic          gap_starve
);
  // R3: the address enable never overlaps the refresh phase.
  a_r3_enable_off_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> !addr_en);

  // R2: the access strobes and the refresh strobe never overlap.
  a_r2_access_refresh_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_sel, refresh}));

  // R4: restore lies inside refresh.
  a_r4_restore_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    restore |-> refresh);

  // R5: data_valid lasts a single cycle and falls inside the restore window.
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  a_r5_valid_in_restore: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> restore);

  // R7: an early edge raises the flag and does not restart the count.
  a_r7_early_flags: assert property (@(posedge clk) disable iff (!rst_n)
    edge_early |=> cycle_violation);
  a_r7_early_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    edge_early |=> (tick != '0));

  // R9: a starved interval raises the refresh flag.
  a_r9_starve_flags: assert property (@(posedge clk) disable iff (!rst_n)
    gap_starve |=> refresh_violation);

  // R10: both flags are sticky.
  a_r10_cycle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_violation |=> cycle_violation);
  a_r10_refresh_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_violation |=> refresh_violation);
endmodule

bind refresh_phase_sequencer rps_checker #(.TW(TW)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .row_sel           (row_sel),
  .addr_en           (addr_en),
  .refresh           (refresh),
  .restore           (restore),
  .data_valid        (data_valid),
  .cycle_violation   (cycle_violation),
  .refresh_violation (refresh_violation),
  .tick              (tick),
  .edge_early        (edge_early),
  .gap_starve        (gap_starve)
);

// File: tb/refresh_phase_sequencer_tb.sv
module refresh_phase_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_clk = 1'b0;
  logic row_sel, addr_en, refresh, restore, data_valid;
  logic cycle_violation, refresh_violation;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model state: tick shown, sequence started, flags.
  int mt = 0;
  bit mact = 1'b0;
  bit mcf = 1'b0;
  bit mrf = 1'b0;

  always #4 clk = ~clk;

  refresh_phase_sequencer u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .cyc_clk           (cyc_clk),
    .row_sel           (row_sel),
    .addr_en           (addr_en),
    .refresh           (refresh),
    .restore           (restore),
    .data_valid        (data_valid),
    .cycle_violation   (cycle_violation),
    .refresh_violation (refresh_violation)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at tick %0d: actual %b expected %b", tag, what, mt, got, exp);
    end
  endtask

  // Compare every output against the arithmetic model of the current tick.
  task automatic check_all();
    bit late;
    late = mact && (mt >= 36);
    chk(late ? "R6" : "R2", "row_sel",    row_sel,    mact && mt < 20);
    chk(late ? "R6" : "R3", "addr_en",    addr_en,    mact && mt < 20);
    chk(late ? "R6" : "R3", "refresh",    refresh,    mact && mt >= 22 && mt < 36);
    chk(late ? "R6" : "R4", "restore",    restore,    mact && mt >= 24 && mt < 36);
    chk("R5", "data_valid", data_valid, mact && mt == 25);
    chk("R7", "cycle_violation",   cycle_violation,   mcf);
    chk("R9", "refresh_violation", refresh_violation, mrf);
  endtask

  // One sampling edge; raise_it puts a rising edge on cyc_clk for that edge.
  task automatic step(input bit raise_it);
    bit acc;
    cyc_clk = raise_it;
    acc = raise_it && (!mact || mt + 1 >= 40);
    if (raise_it && !acc) mcf = 1'b1;
    if (!acc && mt == 119) mrf = 1'b1;
    if (acc) begin
      mt = 0;
      mact = 1'b1;
    end else if (mt < 120) begin
      mt++;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic cycle_gap(input int g);
    repeat (g - 1) step(1'b0);
    step(1'b1);
  endtask

  task automatic do_reset();
    cyc_clk = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "row_sel",           row_sel,           1'b0);
    chk("R1", "addr_en",           addr_en,           1'b0);
    chk("R1", "refresh",           refresh,           1'b0);
    chk("R1", "restore",           restore,           1'b0);
    chk("R1", "data_valid",        data_valid,        1'b0);
    chk("R1", "cycle_violation",   cycle_violation,   1'b0);
    chk("R1", "refresh_violation", refresh_violation, 1'b0);
    rst_n = 1'b1;
    mt = 0;
    mact = 1'b0;
    mcf = 1'b0;
    mrf = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    step(1'b0);
    // R11: an edge only two sampling edges after reset is accepted.
    step(1'b1);
    chk("R11", "row_sel after first edge", row_sel, 1'b1);
    // R8: exact minimum spacing is accepted without a flag.
    cycle_gap(40);
    chk("R8", "row_sel at spacing 40", row_sel, 1'b1);
    chk("R8", "cycle_violation at spacing 40", cycle_violation, 1'b0);
    // Sweep of legal spacings; every tick of every phase is compared.
    for (int g = 41; g <= 120; g += 7) cycle_gap(g);
    // R7: early edges in the access, refresh and idle phases are ignored.
    cycle_gap(10);
    chk("R7", "cycle_violation after early edge", cycle_violation, 1'b1);
    chk("R7", "row_sel after ignored edge", row_sel, 1'b1);
    cycle_gap(50);
    cycle_gap(25);
    chk("R7", "restore after ignored edge in refresh", restore, 1'b1);
    cycle_gap(50);
    cycle_gap(39);
    chk("R7", "row_sel after ignored edge at 39", row_sel, 1'b0);
    cycle_gap(50);
    // R9: an edge exactly at the limit wins over starvation.
    cycle_gap(120);
    chk("R9", "refresh_violation at spacing 120", refresh_violation, 1'b0);
    cycle_gap(121);
    chk("R9", "refresh_violation at spacing 121", refresh_violation, 1'b1);
    // R10: both flags hold through further legal cycles.
    cycle_gap(60);
    cycle_gap(60);
    chk("R10", "cycle_violation held", cycle_violation, 1'b1);
    chk("R10", "refresh_violation held", refresh_violation, 1'b1);
    // R1: reset clears the flags; then starvation counted from reset (R9).
    @(negedge clk);
    do_reset();
    repeat (125) step(1'b0);
    chk("R9", "refresh_violation from reset", refresh_violation, 1'b1);
    chk("R11", "no strobe without an edge", row_sel, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule